// File: doc/BRIEF.md
# Programming Link Session Sequencer

This controller runs one session of a two-wire programming link. It sits on top of a serial transceiver, which moves individual frames. The sequencer tells that transceiver when to send an idle-line break, when to send a byte and when to receive a byte. It also owns the target's active-low reset line and the output enable of the link's data and clock pins.

Three single-cycle commands drive it.
- **Start** opens a session. The target reset is pulled low and held for a minimum number of cycles. The link pins are then enabled, idling high, and a fixed number of break frames (two by default) is sent.
- **Poll** waits for the target's memory controller to become ready. Each round sends the status-load command byte aimed at the status register and receives one reply. The poll succeeds as soon as the ready bit of the reply is set. A counter loaded at the start of the poll counts down on millisecond ticks. If the ready bit is still clear when that counter reaches zero, the poll reports a timeout.
- **Stop** releases the link pins to high impedance and releases the reset line, so the target starts its own program.

Each operation ends with a one-cycle done pulse. The success and timeout flags stay valid after that pulse until the next command is accepted.

Top module: `link_seq_ctrl`

## Requirements
- R1: After reset, `tgt_rst_n_o` is 1 and `link_oe_o` is 0. `brk_req_o`, `tx_req_o`, `rx_req_o`, `done_o`, `ok_o` and `timeout_o` are all 0.
- R2: An accepted start drives `tgt_rst_n_o` to 0 on the next cycle. It stays 0 for the whole session, up to the accepted stop.
- R3: The first `brk_req_o` comes only after `tgt_rst_n_o` has been low for at least HOLD_CYCLES cycles. `link_oe_o` is 1 whenever a break is requested.
- R4: Entry issues exactly N_BREAKS break requests. Each waits for its `xcvr_ack_i`. No byte request is made during entry. Entry then ends with `done_o` and `ok_o`=1.
- R5: Each poll round raises `tx_req_o` with `tx_byte_o` = 0x80 (status-load command 0x80 ORed with status address 0x00). After that request's acknowledge, it raises one `rx_req_o`. Only one request line is high at a time.
- R6: A poll ends with `ok_o`=1 and `timeout_o`=0 on the first reply in which bit 1 (mask 0x02) is set. All other bits of the reply are ignored: 0xFD counts as not ready.
- R7: A reply with bit 1 clear, while the timeout counter is non-zero, starts another command/reply round.
- R8: The timeout counter is loaded with TIMEOUT_MS when a poll is accepted. It counts down by one for each cycle with `tick_ms_i`=1 and saturates at zero. It does not depend on how many rounds are in flight, and it never carries counts from an earlier poll.
- R9: A reply with bit 1 clear, while the timeout counter is zero, ends the poll with `timeout_o`=1 and `ok_o`=0.
- R10: An accepted stop, on the next cycle, sets `tgt_rst_n_o` to 1 and `link_oe_o` to 0, and pulses `done_o` with `ok_o`=1.
- R11: Commands are taken only while no operation is running. Start is ignored inside a session. Poll and stop are ignored outside one. Any command that arrives during an operation is ignored.
- R12: `done_o` is high for exactly one cycle per operation. Exactly one of `ok_o` and `timeout_o` is 1 at that time, and both hold their values until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Open-session command pulse |
| poll_i | input | 1 | Readiness-poll command pulse |
| stop_i | input | 1 | Close-session command pulse |
| tick_ms_i | input | 1 | One-cycle pulse once per millisecond |
| xcvr_ack_i | input | 1 | Transceiver finished the pending request |
| xcvr_rx_byte_i | input | 8 | Received byte, valid with an acknowledge of a receive |
| brk_req_o | output | 1 | Request one break frame |
| tx_req_o | output | 1 | Request transmission of `tx_byte_o` |
| tx_byte_o | output | 8 | Byte to transmit |
| rx_req_o | output | 1 | Request reception of one byte |
| link_oe_o | output | 1 | 1 drives data and clock pins, 0 releases them |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| done_o | output | 1 | Operation complete, one cycle |
| ok_o | output | 1 | Last operation succeeded |
| timeout_o | output | 1 | Last poll ran out of time |

## Verification
The bench builds the block with TIMEOUT_MS=5 and HOLD_CYCLES=6, with N_BREAKS left at 2.

The short timeout brings the expiry point within reach after a handful of replies. This lets the bench place the last not-ready reply exactly on, and exactly one before, the round where the counter reaches zero. Its transceiver model inserts zero to three ticks per reply, which shows that the countdown follows ticks and not rounds.

The longer hold makes the reset-to-first-break delay easy to tell apart from a one- or two-cycle path.

// File: rtl/lsq_pkg.sv
// Package: shared state encoding and command constants for the link session sequencer.
// Assumes: one request to the transceiver is outstanding at most.
package lsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_BRK_REQ,
        ST_BRK_WAIT,
        ST_TX_REQ,
        ST_TX_WAIT,
        ST_RX_REQ,
        ST_RX_WAIT
    } lsq_state_e;

    localparam logic [7:0] CMD_LOAD_CS = 8'h80;
    localparam logic [7:0] ADDR_STATUS = 8'h00;
endpackage

// File: rtl/lsq_hold_timer.sv
// Module: counts how long the sequencer has spent in the reset-hold phase.
// Assumes: run_i stays high for the whole hold phase and drops right after elapsed_o.
module lsq_hold_timer #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic elapsed_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles while running, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign elapsed_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/lsq_ms_timer.sv
// Module: poll timeout counter, loaded per poll and decremented on millisecond ticks.
// Assumes: load_i is a single-cycle pulse; tick_i is at most one cycle wide per tick.
module lsq_ms_timer #(
    parameter int TIMEOUT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int TW = $clog2(TIMEOUT_MS + 1);
    localparam logic [TW-1:0] START = TW'(TIMEOUT_MS);

    logic [TW-1:0] cnt_q;

    // Load has priority; ticks count down and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (load_i) cnt_q <= START;
        else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/link_seq_ctrl.sv
// Module: session sequencer for a two-wire programming link.
// Handles entry (reset hold then breaks), readiness polling with timeout, and exit.
// Assumes: the transceiver answers every request with exactly one xcvr_ack_i pulse,
// and xcvr_rx_byte_i is valid in the acknowledge cycle of a receive request.
module link_seq_ctrl #(
    parameter int         HOLD_CYCLES = 4,
    parameter int         N_BREAKS    = 2,
    parameter int         TIMEOUT_MS  = 100,
    parameter int         READY_BIT   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       poll_i,
    input  logic       stop_i,
    input  logic       tick_ms_i,
    input  logic       xcvr_ack_i,
    input  logic [7:0] xcvr_rx_byte_i,
    output logic       brk_req_o,
    output logic       tx_req_o,
    output logic [7:0] tx_byte_o,
    output logic       rx_req_o,
    output logic       link_oe_o,
    output logic       tgt_rst_n_o,
    output logic       done_o,
    output logic       ok_o,
    output logic       timeout_o
);
    import lsq_pkg::*;

    localparam int BW = $clog2(N_BREAKS + 1);
    localparam logic [BW-1:0] LAST_BRK = BW'(N_BREAKS - 1);
    localparam logic [7:0] POLL_BYTE = CMD_LOAD_CS | ADDR_STATUS;
    localparam logic [7:0] READY_MASK = 8'(1) << READY_BIT;

    lsq_state_e    st_q;
    logic          in_sess_q;
    logic          rst_line_q;
    logic          oe_q;
    logic          done_q;
    logic          ok_q;
    logic          to_q;
    logic [BW-1:0] brk_cnt_q;

    logic acc_start, acc_stop, acc_poll;
    logic hold_elapsed, tmr_expired, reply_ready;

    // Decode which command, if any, is accepted this cycle.
    always_comb begin
        acc_start = (st_q == ST_IDLE) && start_i && !in_sess_q;
        acc_stop  = (st_q == ST_IDLE) && stop_i  && in_sess_q;
        acc_poll  = (st_q == ST_IDLE) && poll_i  && in_sess_q && !stop_i;
    end

    assign reply_ready = (xcvr_rx_byte_i & READY_MASK) != 8'h00;

    lsq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q == ST_HOLD),
        .elapsed_o (hold_elapsed)
    );

    lsq_ms_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (acc_poll),
        .tick_i    (tick_ms_i),
        .expired_o (tmr_expired)
    );

    // Session state machine with its line, result and break-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            in_sess_q  <= 1'b0;
            rst_line_q <= 1'b1;
            oe_q       <= 1'b0;
            done_q     <= 1'b0;
            ok_q       <= 1'b0;
            to_q       <= 1'b0;
            brk_cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (acc_start) begin
                        in_sess_q  <= 1'b1;
                        rst_line_q <= 1'b0;
                        ok_q       <= 1'b0;
                        to_q       <= 1'b0;
                        st_q       <= ST_HOLD;
                    end else if (acc_stop) begin
                        in_sess_q  <= 1'b0;
                        rst_line_q <= 1'b1;
                        oe_q       <= 1'b0;
                        done_q     <= 1'b1;
                        ok_q       <= 1'b1;
                        to_q       <= 1'b0;
                    end else if (acc_poll) begin
                        ok_q <= 1'b0;
                        to_q <= 1'b0;
                        st_q <= ST_TX_REQ;
                    end
                end
                ST_HOLD: begin
                    if (hold_elapsed) begin
                        oe_q      <= 1'b1;
                        brk_cnt_q <= '0;
                        st_q      <= ST_BRK_REQ;
                    end
                end
                ST_BRK_REQ: st_q <= ST_BRK_WAIT;
                ST_BRK_WAIT: begin
                    if (xcvr_ack_i) begin
                        if (brk_cnt_q == LAST_BRK) begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            brk_cnt_q <= brk_cnt_q + 1'b1;
                            st_q      <= ST_BRK_REQ;
                        end
                    end
                end
                ST_TX_REQ: st_q <= ST_TX_WAIT;
                ST_TX_WAIT: if (xcvr_ack_i) st_q <= ST_RX_REQ;
                ST_RX_REQ: st_q <= ST_RX_WAIT;
                ST_RX_WAIT: begin
                    if (xcvr_ack_i) begin
                        if (reply_ready) begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else if (tmr_expired) begin
                            done_q <= 1'b1;
                            to_q   <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_TX_REQ;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign brk_req_o   = (st_q == ST_BRK_REQ);
    assign tx_req_o    = (st_q == ST_TX_REQ);
    assign rx_req_o    = (st_q == ST_RX_REQ);
    assign tx_byte_o   = POLL_BYTE;
    assign link_oe_o   = oe_q;
    assign tgt_rst_n_o = rst_line_q;
    assign done_o      = done_q;
    assign ok_o        = ok_q;
    assign timeout_o   = to_q;
endmodule

// File: rtl/link_seq_ctrl_chk.sv
// Module: property checker for link_seq_ctrl, attached by bind below.
// Assumes: it sees only the top-level ports.
module link_seq_ctrl_chk #(
    parameter int HOLD_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       brk_req_o,
    input logic       tx_req_o,
    input logic [7:0] tx_byte_o,
    input logic       rx_req_o,
    input logic       link_oe_o,
    input logic       tgt_rst_n_o,
    input logic       done_o,
    input logic       ok_o,
    input logic       timeout_o
);
    int low_cnt;

    // Measure how long reset has been held low, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n || tgt_rst_n_o) low_cnt <= 0;
        else if (low_cnt < HOLD_CYCLES) low_cnt <= low_cnt + 1;
    end

    p_oe_in_session_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_oe_o |-> !tgt_rst_n_o);
    p_hold_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |-> (low_cnt >= HOLD_CYCLES));
    p_brk_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |-> link_oe_o);
    p_one_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({brk_req_o, tx_req_o, rx_req_o}));
    p_poll_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> (tx_byte_o == 8'h80));
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n_o) |-> (!link_oe_o && done_o && ok_o));
    p_byte_in_session_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_o || rx_req_o) |-> !tgt_rst_n_o);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o ^ timeout_o));
endmodule

bind link_seq_ctrl link_seq_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_req_o   (brk_req_o),
    .tx_req_o    (tx_req_o),
    .tx_byte_o   (tx_byte_o),
    .rx_req_o    (rx_req_o),
    .link_oe_o   (link_oe_o),
    .tgt_rst_n_o (tgt_rst_n_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .timeout_o   (timeout_o)
);

// File: tb/sim_link_seq_ctrl.sv
`timescale 1ns/1ps
module sim_link_seq_ctrl;
    localparam int HOLD = 6;
    localparam int TMO  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, poll_i = 1'b0, stop_i = 1'b0;
    logic       tick_ms_i = 1'b0, xcvr_ack_i = 1'b0;
    logic [7:0] xcvr_rx_byte_i = 8'h00;
    logic       brk_req_o, tx_req_o, rx_req_o, link_oe_o, tgt_rst_n_o;
    logic       done_o, ok_o, timeout_o;
    logic [7:0] tx_byte_o;

    int n_chk = 0, n_bad = 0;
    int brk_cnt = 0, tx_cnt = 0, rx_cnt = 0, bad_byte = 0;
    int m_ticks = 0, m_notready = 0, resp_idx = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    link_seq_ctrl #(.HOLD_CYCLES(HOLD), .N_BREAKS(2), .TIMEOUT_MS(TMO), .READY_BIT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_i(poll_i), .stop_i(stop_i),
        .tick_ms_i(tick_ms_i), .xcvr_ack_i(xcvr_ack_i), .xcvr_rx_byte_i(xcvr_rx_byte_i),
        .brk_req_o(brk_req_o), .tx_req_o(tx_req_o), .tx_byte_o(tx_byte_o), .rx_req_o(rx_req_o),
        .link_oe_o(link_oe_o), .tgt_rst_n_o(tgt_rst_n_o), .done_o(done_o), .ok_o(ok_o),
        .timeout_o(timeout_o));

    // {ticks per reply, not-ready replies, expected timeout, expected rounds}
    localparam int VEC [0:8][0:3] = '{
        '{1, 0, 0, 1}, '{1, 2, 0, 3}, '{1, 4, 0, 5}, '{1, 9, 1, 5}, '{2, 9, 1, 3},
        '{2, 2, 0, 3}, '{0, 7, 0, 8}, '{3, 9, 1, 2}, '{1, 9, 1, 5}};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Transceiver model: acknowledges each request; ticks and reply data come from the model settings.
    initial begin
        @(negedge clk);
        forever begin
            if (brk_req_o || tx_req_o || rx_req_o) begin
                automatic bit is_rx = rx_req_o;
                if (brk_req_o) brk_cnt++;
                if (tx_req_o) begin
                    tx_cnt++;
                    if (tx_byte_o != 8'h80) bad_byte++;
                end
                if (rx_req_o) rx_cnt++;
                repeat (2) @(negedge clk);
                if (is_rx) begin
                    for (int k = 0; k < m_ticks; k++) begin
                        tick_ms_i = 1'b1; @(negedge clk);
                        tick_ms_i = 1'b0; @(negedge clk);
                    end
                    xcvr_rx_byte_i = (resp_idx >= m_notready) ? 8'h02 : 8'hFD;
                    resp_idx++;
                end
                xcvr_ack_i = 1'b1;
                @(negedge clk);
                xcvr_ack_i = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic pulse_cmd(input int which);
        if (which == 0) start_i = 1'b1; else if (which == 1) poll_i = 1'b1; else stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; poll_i = 1'b0; stop_i = 1'b0;
    endtask

    // Wait for done (current negedge included); returns cycles waited or -1.
    task automatic wait_done(input int limit, output int waited);
        waited = -1;
        for (int c = 0; c < limit; c++) begin
            if (done_o) begin waited = c; return; end
            @(negedge clk);
        end
    endtask

    task automatic count_done(input int cycles, output int seen);
        seen = 0;
        for (int c = 0; c < cycles; c++) begin
            if (done_o) seen++;
            @(negedge clk);
        end
    endtask

    initial begin
        int w, seen, low;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rst line", tgt_rst_n_o, 1);
        check("R1 oe", link_oe_o, 0);
        check("R1 requests", brk_req_o | tx_req_o | rx_req_o, 0);
        check("R1 status", {done_o, ok_o, timeout_o}, 0);

        // R11 poll and stop outside a session are ignored
        pulse_cmd(1);
        count_done(20, seen);
        check("R11 poll outside session done", seen, 0);
        check("R11 poll outside session tx", tx_cnt, 0);
        pulse_cmd(2);
        count_done(10, seen);
        check("R11 stop outside session done", seen, 0);
        check("R11 stop outside session rst", tgt_rst_n_o, 1);

        // R2 R3 R4 entry
        pulse_cmd(0);
        check("R2 reset low after start", tgt_rst_n_o, 0);
        low = 0;
        while (!brk_req_o && low < 100) begin low++; @(negedge clk); end
        check("R3 hold before first break", int'(low >= HOLD), 1);
        check("R3 oe at break", link_oe_o, 1);
        wait_done(200, w);
        check("R4 entry done", int'(w >= 0), 1);
        check("R4 entry ok", ok_o, 1);
        check("R4 entry timeout flag", timeout_o, 0);
        check("R4 break count", brk_cnt, 2);
        check("R4 no bytes during entry", tx_cnt + rx_cnt, 0);
        @(negedge clk);
        check("R12 done one cycle", done_o, 0);
        check("R12 ok held", ok_o, 1);

        // R11 start inside session ignored
        pulse_cmd(0);
        count_done(20, seen);
        check("R11 start in session done", seen, 0);
        check("R11 start in session breaks", brk_cnt, 2);

        // Table of poll vectors: R5 R6 R7 R8 R9
        for (int v = 0; v < 9; v++) begin
            m_ticks = VEC[v][0]; m_notready = VEC[v][1];
            resp_idx = 0; tx_cnt = 0; rx_cnt = 0;
            pulse_cmd(1);
            wait_done(2000, w);
            check($sformatf("R7 vec%0d done", v), int'(w >= 0), 1);
            check($sformatf("R9 vec%0d timeout", v), timeout_o, VEC[v][2]);
            check($sformatf("R6 vec%0d ok", v), ok_o, 1 - VEC[v][2]);
            check($sformatf("R8 vec%0d rounds", v), tx_cnt, VEC[v][3]);
            check($sformatf("R5 vec%0d rx per tx", v), rx_cnt, tx_cnt);
            @(negedge clk);
            check($sformatf("R12 vec%0d done width", v), done_o, 0);
            repeat (3) @(negedge clk);
            check($sformatf("R12 vec%0d result held", v), {ok_o, timeout_o}, VEC[v][2] ? 1 : 2);
            check($sformatf("R2 vec%0d reset still low", v), tgt_rst_n_o, 0);
        end
        check("R5 poll byte value", bad_byte, 0);

        // R11 stop during an active poll is ignored
        m_ticks = 0; m_notready = 6; resp_idx = 0; tx_cnt = 0;
        pulse_cmd(1);
        repeat (5) @(negedge clk);
        pulse_cmd(2);
        pulse_cmd(0);
        wait_done(2000, w);
        check("R11 busy poll ok", ok_o, 1);
        check("R11 busy poll rounds", tx_cnt, 7);
        @(negedge clk);
        check("R11 busy stop ignored", tgt_rst_n_o, 0);
        check("R11 busy start ignored", brk_cnt, 2);

        // R10 stop
        pulse_cmd(2);
        check("R10 done", done_o, 1);
        check("R10 ok", ok_o, 1);
        check("R10 reset released", tgt_rst_n_o, 1);
        check("R10 pins released", link_oe_o, 0);
        @(negedge clk);
        check("R12 stop done width", done_o, 0);

        // R11 poll after stop ignored, then R4 re-entry
        tx_cnt = 0;
        pulse_cmd(1);
        count_done(20, seen);
        check("R11 poll after stop", seen + tx_cnt, 0);
        brk_cnt = 0;
        pulse_cmd(0);
        wait_done(500, w);
        check("R4 re-entry breaks", brk_cnt, 2);
        check("R4 re-entry ok", ok_o, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule